// File: doc/BRIEF.md
# PLL clock control sequencer

This block is the control side of an on-chip clock generator built around a phase-locked loop. Software programs a 4-bit frequency multiplier and a 2-bit post-divider select through a small register port. Writes only land while a software-held unlock flag is high. The block never touches an analog signal. It produces a clock-source select code and a divide ratio for a separate glitch-free clock mux, and it reports lock and reference-loss status.

A multiplier change starts a lock wait. During that wait the system clock falls back to the oscillator divided by two and the lock flag reads low. When the wait ends, the block selects the multiplied clock and raises the lock flag. Two interlocks protect the sequence:
- the post-divider may only be changed while no lock wait is running;
- a multiplier may only be raised from its current value while the divider select is at its slowest setting.

A reference monitor counts cycles between edges of the external reference. If the gap grows too long, it latches a reference-lost flag. That flag forces the limp clock source until reset. Software can mask the monitor while it relocks.

Top module: `clkseq_ctrl`

## Requirements
- R1: After reset: multiplier 0, divider select 0, mask 0, reference-lost 0, lock 0, `clk_src` = 0 (oscillator direct) and `div_log2` = 2.
- R2: A write with `wr_unlock` low changes no register.
- R3: A control write (`wr_sel` = 0) loads the multiplier from `wr_data[3:0]`. A change to a nonzero value is ignored unless the divider select is 0. A change to zero is always accepted.
- R4: After an accepted multiplier change, lock reads 0 and `clk_src` = 1 (oscillator / 2) for exactly LOCK_CYCLES cycles. Lock then reads 1 and `clk_src` = 2 (multiplied clock), or 0 if the multiplier is zero.
- R5: An accepted multiplier change during a lock wait clears lock and restarts the full LOCK_CYCLES wait.
- R6: A status write (`wr_sel` = 1) sets the divider select from `wr_data[1:0]` and the mask from `wr_data[2]`. The divider field is ignored while a lock wait runs. Data bits 3 and 4 are ignored, so lock cannot be written.
- R7: `div_log2` is 2 for divider select 0, 1 for select 1 or 2, and 0 for select 3.
- R8: When no reference edge is seen for more than MISS_TIMEOUT cycles and the mask is 0, reference-lost is set. Edges spaced more closely never set it.
- R9: While the mask is 1, reference-lost never rises, however long the reference stays still.
- R10: Reference-lost holds until reset. While it is set, `clk_src` = 3 (limp) and `div_log2` = 1, whatever the multiplier or divider.
- R11: `status_q` reads {lock, reference-lost, mask, divider select[1:0]}, with lock in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control (multiplier), 1 = status/divider |
| wr_unlock | input | 1 | Write protection enable; writes act only when high |
| wr_data | input | 8 | Write data |
| ref_in | input | 1 | External reference clock, asynchronous |
| mult_q | output | 4 | Current multiplier |
| clk_src | output | 2 | Source code: 0 osc, 1 osc/2, 2 multiplied, 3 limp |
| div_log2 | output | 2 | Post-divide as a power of two |
| status_q | output | 5 | {lock, ref_lost, mask, div_sel[1:0]} |

## Verification
The bench measures the lock wait to the exact cycle. It also restarts the wait mid-count, which shows whether a design lets a retrigger finish early or leaves a stale lock flag high. It tries a divider write during the wait and raises the multiplier while the divider is fast, where a missing interlock would let the divider or multiplier jump. It holds the reference still just short of the timeout, while masked, and past the timeout. This catches a monitor that trips early, ignores the mask, or lets the limp override lapse after a later multiplier write or once the reference returns.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int MULT_W = 4;
  localparam int DSEL_W = 2;
  localparam int STS_W  = DSEL_W + 3;

  typedef enum logic [1:0] {
    SRC_OSC  = 2'd0,
    SRC_HALF = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_LIMP = 2'd3
  } clk_src_e;

  // post-divide expressed as a shift amount
  function automatic logic [1:0] div_shift(input logic [DSEL_W-1:0] dsel);
    case (dsel)
      2'd0:    return 2'd2;
      2'd3:    return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

  // source priority: limp, relock fallback, bypass, multiplied
  function automatic clk_src_e pick_src(input logic lost, input logic busy,
                                        input logic mult_zero);
    if (lost)      return SRC_LIMP;
    if (busy)      return SRC_HALF;
    if (mult_zero) return SRC_OSC;
    return SRC_PLL;
  endfunction
endpackage

// File: rtl/clkseq_lock.sv
module clkseq_lock #(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic locked,
  output logic done
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(LOCK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      locked <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      locked <= 1'b0;
      cnt    <= '0;
    end else if (done) begin
      busy   <= 1'b0;
      locked <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkseq_refmon.sv
module clkseq_refmon #(
  parameter int MISS_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic mask,
  output logic lost,
  output logic ref_edge,
  output logic miss_hit
);
  localparam int CW = $clog2(MISS_TIMEOUT + 1);
  logic [2:0]    ref_sh;
  logic [CW-1:0] gap;

  assign ref_edge = ref_sh[2] ^ ref_sh[1];
  assign miss_hit = (gap == CW'(MISS_TIMEOUT)) && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh <= '0;
      gap    <= '0;
      lost   <= 1'b0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_in};
      if (mask || ref_edge)              gap <= '0;
      else if (gap != CW'(MISS_TIMEOUT)) gap <= gap + 1'b1;
      if (miss_hit) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/clkseq_regs.sv
module clkseq_regs
  import clkseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_unlock,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock_busy,
  output logic [MULT_W-1:0] mult_q,
  output logic [DSEL_W-1:0] dsel_q,
  output logic              mask_q,
  output logic              mult_wr_ok,
  output logic              sts_wr_ok
);
  localparam int MASK_BIT = DSEL_W;

  logic              ctl_wr, sts_wr;
  logic [MULT_W-1:0] mult_new;
  logic              unused_hi;

  assign unused_hi  = ^wr_data[DATA_W-1:MULT_W];
  assign ctl_wr     = wr_en && wr_unlock && !wr_sel;
  assign sts_wr     = wr_en && wr_unlock && wr_sel;
  assign mult_new   = wr_data[MULT_W-1:0];
  assign mult_wr_ok = ctl_wr && (mult_new != mult_q) &&
                      ((mult_new == '0) || (dsel_q == '0));
  assign sts_wr_ok  = sts_wr && !lock_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      dsel_q <= '0;
      mask_q <= 1'b0;
    end else begin
      if (mult_wr_ok) mult_q <= mult_new;
      if (sts_wr)     mask_q <= wr_data[MASK_BIT];
      if (sts_wr_ok)  dsel_q <= wr_data[DSEL_W-1:0];
    end
  end
endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
#(
  parameter int LOCK_CYCLES  = 1024,
  parameter int MISS_TIMEOUT = 64,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_unlock,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ref_in,
  output logic [MULT_W-1:0] mult_q,
  output logic [1:0]        clk_src,
  output logic [1:0]        div_log2,
  output logic [STS_W-1:0]  status_q
);
  logic [DSEL_W-1:0] dsel_q;
  logic mask_q, lock_start, sts_wr_ok;
  logic lock_busy, lock_flag, lock_done;
  logic ref_lost, ref_edge, miss_hit;

  clkseq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_unlock(wr_unlock), .wr_data(wr_data), .lock_busy(lock_busy),
    .mult_q(mult_q), .dsel_q(dsel_q), .mask_q(mask_q),
    .mult_wr_ok(lock_start), .sts_wr_ok(sts_wr_ok)
  );

  clkseq_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(lock_start),
    .busy(lock_busy), .locked(lock_flag), .done(lock_done)
  );

  clkseq_refmon #(.MISS_TIMEOUT(MISS_TIMEOUT)) u_refmon (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mask(mask_q),
    .lost(ref_lost), .ref_edge(ref_edge), .miss_hit(miss_hit)
  );

  assign clk_src  = pick_src(ref_lost, lock_busy, mult_q == '0);
  assign div_log2 = ref_lost ? 2'd1 : div_shift(dsel_q);
  assign status_q = {lock_flag, ref_lost, mask_q, dsel_q};
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk
  import clkseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic              wr_unlock,
  input logic [7:0]        wr_data,
  input logic [MULT_W-1:0] mult_q,
  input logic [1:0]        clk_src,
  input logic [1:0]        div_log2,
  input logic [STS_W-1:0]  status_q,
  input logic              lock_busy,
  input logic              lock_start,
  input logic              miss_hit
);
  a_r2_protected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_unlock |=> $stable(mult_q) && $stable(status_q[2:0]));

  a_r3_mult_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_unlock && !wr_sel && (status_q[1:0] != 2'd0) &&
    (wr_data[3:0] != 4'd0) |=> $stable(mult_q));

  a_r4_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy && !status_q[3] |-> clk_src == SRC_HALF && !status_q[4]);

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    lock_start |=> lock_busy && !status_q[4]);

  a_r6_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy && wr_en && wr_sel |=> $stable(status_q[1:0]));

  a_r8_latch: assert property (@(posedge clk) disable iff (!rst_n)
    miss_hit |=> status_q[3]);

  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[2] |=> !$rose(status_q[3]));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3] |=> status_q[3]);

  a_r10_limp: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[3] |-> clk_src == SRC_LIMP && div_log2 == 2'd1);
endmodule

bind clkseq_ctrl clkseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_unlock(wr_unlock), .wr_data(wr_data), .mult_q(mult_q),
  .clk_src(clk_src), .div_log2(div_log2), .status_q(status_q),
  .lock_busy(lock_busy), .lock_start(lock_start), .miss_hit(miss_hit)
);

// File: tb/test_clkseq_ctrl.sv
module test_clkseq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 40;
  localparam int TO   = 24;

  typedef struct packed {
    logic       sel;
    logic [7:0] data;
    logic       unl;
    logic [3:0] e_mult;
    logic [1:0] e_dsel;
    logic       e_lock;
    logic       wt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h05, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0},  // R2 locked out
    '{1'b0, 8'h05, 1'b1, 4'h5, 2'd0, 1'b1, 1'b1},  // R3 accepted
    '{1'b1, 8'h03, 1'b1, 4'h5, 2'd3, 1'b1, 1'b0},  // R6 div 3
    '{1'b0, 8'h07, 1'b1, 4'h5, 2'd3, 1'b1, 1'b0},  // R3 blocked, div fast
    '{1'b0, 8'h00, 1'b1, 4'h0, 2'd3, 1'b1, 1'b1},  // R3 to zero allowed
    '{1'b0, 8'h09, 1'b1, 4'h0, 2'd3, 1'b1, 1'b0},  // R3 blocked
    '{1'b1, 8'h10, 1'b1, 4'h0, 2'd0, 1'b1, 1'b0},  // R6 lock bit ignored
    '{1'b0, 8'h09, 1'b1, 4'h9, 2'd0, 1'b1, 1'b1},  // R3
    '{1'b1, 8'h02, 1'b0, 4'h9, 2'd0, 1'b1, 1'b0},  // R2
    '{1'b1, 8'h12, 1'b1, 4'h9, 2'd2, 1'b1, 1'b0}   // R6
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, wr_unlock = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ref_in = 1'b0;
  logic       ref_run = 1'b1;
  logic [3:0] mult_q;
  logic [1:0] clk_src, div_log2;
  logic [4:0] status_q;
  int n_chk = 0, n_err = 0;

  clkseq_ctrl #(.LOCK_CYCLES(LOCK), .MISS_TIMEOUT(TO)) i_clkseq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_unlock(wr_unlock), .wr_data(wr_data), .ref_in(ref_in),
    .mult_q(mult_q), .clk_src(clk_src), .div_log2(div_log2),
    .status_q(status_q)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (ref_run) ref_in = ~ref_in;
  end

  function automatic logic [1:0] want_div(input logic [1:0] d);
    if (d == 2'd3) return 2'd0;
    if (d == 2'd0) return 2'd2;
    return 2'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, input logic unl);
    wr_sel = sel; wr_data = d; wr_unlock = unl; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic chk_reset_state();
    chk("R1 mult", 32'(mult_q), 0);
    chk("R1 status", 32'(status_q), 0);
    chk("R1 clk_src", 32'(clk_src), 0);
    chk("R1 div_log2", 32'(div_log2), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state();  // R1

    // table walk: R2 R3 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      wr(v.sel, v.data, v.unl);
      if (v.wt) repeat (LOCK + 2) @(negedge clk);
      chk("R3 mult", 32'(mult_q), 32'(v.e_mult));
      chk("R11 status", 32'(status_q), 32'({v.e_lock, 2'b00, v.e_dsel}));
      chk("R7 div_log2", 32'(div_log2), 32'(want_div(v.e_dsel)));
      chk("R4 clk_src", 32'(clk_src), (v.e_mult == 0) ? 0 : 2);
    end

    // R4 exact lock window
    wr(1'b1, 8'h00, 1'b1);
    wr(1'b0, 8'h03, 1'b1);
    chk("R4 lock low", 32'(status_q[4]), 0);
    chk("R4 half src", 32'(clk_src), 1);
    repeat (LOCK - 1) @(negedge clk);
    chk("R4 still waiting", 32'(status_q[4]), 0);
    chk("R4 still half", 32'(clk_src), 1);
    @(negedge clk);
    chk("R4 locked", 32'(status_q[4]), 1);
    chk("R4 pll src", 32'(clk_src), 2);

    // R6 divider gated during wait, R5 restart
    wr(1'b0, 8'h04, 1'b1);
    repeat (10) @(negedge clk);
    wr(1'b1, 8'h03, 1'b1);
    chk("R6 div held while busy", 32'(status_q[1:0]), 0);
    wr(1'b0, 8'h06, 1'b1);
    chk("R5 mult", 32'(mult_q), 6);
    repeat (LOCK - 1) @(negedge clk);
    chk("R5 restarted wait", 32'(status_q[4]), 0);
    @(negedge clk);
    chk("R5 lock after full wait", 32'(status_q[4]), 1);

    // R7 divide mapping
    wr(1'b1, 8'h03, 1'b1);
    chk("R7 sel3", 32'(div_log2), 0);
    wr(1'b1, 8'h01, 1'b1);
    chk("R7 sel1", 32'(div_log2), 1);
    wr(1'b1, 8'h00, 1'b1);
    chk("R7 sel0", 32'(div_log2), 2);

    // R8 gap just below timeout
    ref_run = 1'b0;
    repeat (TO - 6) @(negedge clk);
    chk("R8 no early loss", 32'(status_q[3]), 0);
    ref_run = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 no loss with edges", 32'(status_q[3]), 0);

    // R9 masked
    wr(1'b1, 8'h04, 1'b1);
    ref_run = 1'b0;
    repeat (3 * TO) @(negedge clk);
    chk("R9 masked no loss", 32'(status_q[3]), 0);
    chk("R9 mask readback", 32'(status_q[2]), 1);
    ref_run = 1'b1;
    repeat (10) @(negedge clk);
    wr(1'b1, 8'h00, 1'b1);
    repeat (5) @(negedge clk);

    // R8 loss, R10 limp override
    ref_run = 1'b0;
    repeat (TO + 10) @(negedge clk);
    chk("R8 loss flagged", 32'(status_q[3]), 1);
    chk("R10 limp src", 32'(clk_src), 3);
    chk("R10 limp div", 32'(div_log2), 1);
    wr(1'b0, 8'h02, 1'b1);
    repeat (LOCK + 2) @(negedge clk);
    chk("R10 mult written", 32'(mult_q), 2);
    chk("R10 still limp", 32'(clk_src), 3);
    ref_run = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 sticky", 32'(status_q[3]), 1);

    // R1 reset again
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule